// File: doc/BRIEF.md
# Differential Quadrature Phase Symbol Codec

This block turns a stream of two-bit symbols into a sequence of absolute carrier phases, where each symbol selects how far the phase turns from the previous one. It also does the reverse: from received absolute phases it recovers the symbols. Phases are counted in quarter turns, so a 2-bit index from 0 to 3 stands for 0, 90, 180 and 270 degrees, and the index grows counterclockwise.

Two modes are supported. The four-point mode uses every dibit. The two-point mode uses only the "no turn" and "half turn" changes. A runtime control bit reverses the sense of rotation on both the transmit and receive paths. Each path has its own start-of-packet strobe, which resets that path's reference phase to zero. The receive path decodes each symbol against the phase received just before it. Because of this, one wrong received phase corrupts two decoded symbols.

Top module: `dq_symbol_codec`

## Requirements
- R1: When tx_valid is high in four-point mode with rev_dir=0, the transmit phase advances by a step set by tx_dibit: 00→0, 01→+1, 11→+2, 10→+3 (that is, −1) quarter turns, modulo 4. The new phase appears on tx_phase, with tx_phase_valid high, one clock after the input.
- R2: When rx_valid is high in four-point mode with rev_dir=0, the decoder takes the difference d = (rx_phase − reference) mod 4 and maps it to the dibit 0→00, 1→01, 2→11, 3→10. The result appears on rx_dibit, with rx_out_valid high, one clock later. The received phase then becomes the new reference.
- R3: With rev_dir=1, the transmit step is negated modulo 4, and the receive difference is negated modulo 4 before the mapping.
- R4: In two-point mode (bpsk_mode=1), the transmitter uses only tx_dibit[1]: 0 gives a step of 0 and 1 gives a step of +2 before any reversal. tx_dibit[0] has no effect.
- R5: In two-point mode, the receiver takes bit b as bit 1 of the (possibly negated) difference, so 0 and +1 quarter turns give 0 and +2 and +3 give 1. It outputs rx_dibit = {b,b}.
- R6: When tx_sop is high, the transmit reference is taken as 0 for a symbol in the same cycle. When tx_sop is high without tx_valid, tx_phase is cleared to 0 and tx_phase_valid stays low.
- R7: When rx_sop is high, the receive reference is 0 for a symbol in the same cycle. When rx_sop is high without rx_valid, the reference is cleared for the next symbol.
- R8: In a cycle with no valid and no strobe, the references do not change and tx_phase holds its value. Each output valid goes low one clock after a cycle without input valid.
- R9: During reset and right after it, tx_phase is 0, both output valids are low and both references are 0.
- R10: A single wrong received phase inside a stream changes exactly two consecutive decoded symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rev_dir | input | 1 | Reverse rotation sense |
| bpsk_mode | input | 1 | Two-point mode select |
| tx_sop | input | 1 | Transmit start of packet, reference to 0 |
| tx_valid | input | 1 | Transmit symbol present |
| tx_dibit | input | 2 | Transmit symbol |
| tx_phase_valid | output | 1 | tx_phase carries a new symbol |
| tx_phase | output | 2 | Absolute transmit phase, quarter turns |
| rx_sop | input | 1 | Receive start of packet, reference to 0 |
| rx_valid | input | 1 | Received phase present |
| rx_phase | input | 2 | Absolute received phase, quarter turns |
| rx_out_valid | output | 1 | rx_dibit carries a decoded symbol |
| rx_dibit | output | 2 | Decoded symbol |

## Verification
The hardest case to reach is a single corrupted phase inside an otherwise clean stream, where the two-symbol error spread must show. To build it, the bench loops symbols through the transmitter and stores the phases it emits. It then replays them into the receiver with exactly one phase shifted by a quarter turn, and counts the decoded symbols that differ from the ones sent. Random stimulus mixes modes, reversal and mid-stream strobes, and a bench model keeps its own references for both paths.

// File: rtl/dq_codec_pkg.sv
package dq_codec_pkg;
  localparam int PH_W = 2;
  typedef logic [PH_W-1:0] phase_t;
  typedef logic [1:0]      dibit_t;

  function automatic phase_t dibit_to_step(input dibit_t d);
    case (d)
      2'b00:   return phase_t'(0);
      2'b01:   return phase_t'(1);
      2'b11:   return phase_t'(2);
      default: return phase_t'(3);
    endcase
  endfunction

  function automatic dibit_t step_to_dibit(input phase_t s);
    case (s)
      phase_t'(0): return 2'b00;
      phase_t'(1): return 2'b01;
      phase_t'(2): return 2'b11;
      default:     return 2'b10;
    endcase
  endfunction

  function automatic phase_t apply_sense(input phase_t s, input logic rev);
    return rev ? phase_t'(phase_t'(0) - s) : s;
  endfunction
endpackage

// File: rtl/dq_tx_encoder.sv
module dq_tx_encoder
  import dq_codec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rev_dir,
  input  logic   bpsk_mode,
  input  logic   sop,
  input  logic   valid,
  input  dibit_t dibit,
  output phase_t step_o,
  output phase_t phase_o,
  output logic   phase_valid_o
);
  phase_t acc_q;
  logic   pv_q;
  dibit_t eff_dibit;
  phase_t base;

  always_comb begin
    eff_dibit = bpsk_mode ? {dibit[1], dibit[1]} : dibit;
    step_o    = apply_sense(dibit_to_step(eff_dibit), rev_dir);
    base      = sop ? phase_t'(0) : acc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      pv_q  <= 1'b0;
    end else begin
      pv_q <= valid;
      if (valid)    acc_q <= phase_t'(base + step_o);
      else if (sop) acc_q <= '0;
    end
  end

  assign phase_o       = acc_q;
  assign phase_valid_o = pv_q;
endmodule

// File: rtl/dq_rx_decoder.sv
module dq_rx_decoder
  import dq_codec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rev_dir,
  input  logic   bpsk_mode,
  input  logic   sop,
  input  logic   valid,
  input  phase_t phase,
  output phase_t diff_o,
  output dibit_t dibit_o,
  output logic   out_valid_o
);
  phase_t ref_q;
  dibit_t out_q;
  logic   ov_q;
  phase_t base;
  dibit_t decoded;

  always_comb begin
    base    = sop ? phase_t'(0) : ref_q;
    diff_o  = apply_sense(phase_t'(phase - base), rev_dir);
    decoded = bpsk_mode ? {diff_o[PH_W-1], diff_o[PH_W-1]} : step_to_dibit(diff_o);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= '0;
      out_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      ov_q <= valid;
      if (valid) begin
        ref_q <= phase;
        out_q <= decoded;
      end else if (sop) begin
        ref_q <= '0;
      end
    end
  end

  assign dibit_o     = out_q;
  assign out_valid_o = ov_q;
endmodule

// File: rtl/dq_symbol_codec.sv
module dq_symbol_codec
  import dq_codec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rev_dir,
  input  logic       bpsk_mode,
  input  logic       tx_sop,
  input  logic       tx_valid,
  input  logic [1:0] tx_dibit,
  output logic       tx_phase_valid,
  output logic [1:0] tx_phase,
  input  logic       rx_sop,
  input  logic       rx_valid,
  input  logic [1:0] rx_phase,
  output logic       rx_out_valid,
  output logic [1:0] rx_dibit
);
  phase_t tx_step;
  phase_t rx_diff;

  dq_tx_encoder u_tx (
    .clk(clk), .rst_n(rst_n), .rev_dir(rev_dir), .bpsk_mode(bpsk_mode),
    .sop(tx_sop), .valid(tx_valid), .dibit(tx_dibit),
    .step_o(tx_step), .phase_o(tx_phase), .phase_valid_o(tx_phase_valid)
  );

  dq_rx_decoder u_rx (
    .clk(clk), .rst_n(rst_n), .rev_dir(rev_dir), .bpsk_mode(bpsk_mode),
    .sop(rx_sop), .valid(rx_valid), .phase(rx_phase),
    .diff_o(rx_diff), .dibit_o(rx_dibit), .out_valid_o(rx_out_valid)
  );
endmodule

// File: rtl/dq_codec_checker.sv
module dq_codec_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rev_dir,
  input logic       bpsk_mode,
  input logic       tx_sop,
  input logic       tx_valid,
  input logic [1:0] tx_dibit,
  input logic       tx_phase_valid,
  input logic [1:0] tx_phase,
  input logic       rx_sop,
  input logic       rx_valid,
  input logic [1:0] rx_phase,
  input logic       rx_out_valid,
  input logic [1:0] rx_dibit
);
  AST_TX_ZERO_STEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_sop && !bpsk_mode && tx_dibit == 2'b00 |=> $stable(tx_phase)); // R1
  AST_RX_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_out_valid); // R2
  AST_TX_HALF_TURN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bpsk_mode && tx_valid && !tx_sop |=> tx_phase[0] == $past(tx_phase[0])); // R4
  AST_RX_TWO_POINT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    bpsk_mode && rx_valid |=> rx_dibit[1] == rx_dibit[0]); // R5
  AST_TX_SOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sop && !tx_valid |=> tx_phase == 2'd0 && !tx_phase_valid); // R6
  AST_RX_SOP_ZERO_REF: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sop && rx_valid && rx_phase == 2'd0 |=> rx_dibit == 2'b00); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid && !tx_sop |=> $stable(tx_phase) && !tx_phase_valid); // R8
  AST_RX_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !rx_out_valid); // R8
endmodule

bind dq_symbol_codec dq_codec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rev_dir(rev_dir), .bpsk_mode(bpsk_mode),
  .tx_sop(tx_sop), .tx_valid(tx_valid), .tx_dibit(tx_dibit),
  .tx_phase_valid(tx_phase_valid), .tx_phase(tx_phase),
  .rx_sop(rx_sop), .rx_valid(rx_valid), .rx_phase(rx_phase),
  .rx_out_valid(rx_out_valid), .rx_dibit(rx_dibit)
);

// File: tb/dq_symbol_codec_bench.sv
module dq_symbol_codec_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rev_dir = 1'b0, bpsk_mode = 1'b0;
  logic tx_sop = 1'b0, tx_valid = 1'b0, rx_sop = 1'b0, rx_valid = 1'b0;
  logic [1:0] tx_dibit = '0, rx_phase = '0;
  logic tx_phase_valid, rx_out_valid;
  logic [1:0] tx_phase, rx_dibit;

  int vectors = 0, errors = 0, cycles = 0;
  logic [1:0] m_tx_ref = '0, m_rx_ref = '0;
  logic [1:0] sent [0:19];
  logic [1:0] phs [0:19];
  logic [1:0] got [0:19];

  always #5 clk = ~clk;

  dq_symbol_codec u_dq_symbol_codec (
    .clk(clk), .rst_n(rst_n), .rev_dir(rev_dir), .bpsk_mode(bpsk_mode),
    .tx_sop(tx_sop), .tx_valid(tx_valid), .tx_dibit(tx_dibit),
    .tx_phase_valid(tx_phase_valid), .tx_phase(tx_phase),
    .rx_sop(rx_sop), .rx_valid(rx_valid), .rx_phase(rx_phase),
    .rx_out_valid(rx_out_valid), .rx_dibit(rx_dibit)
  );

  // Gray relation: step bits are {d1, d1^d0}, and back again
  function automatic logic [1:0] b_step(input logic [1:0] d);
    return {d[1], d[1] ^ d[0]};
  endfunction
  function automatic logic [1:0] b_dibit(input logic [1:0] s);
    return {s[1], s[1] ^ s[0]};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      summary_and_end();
    end
  end

  // One cycle: drive at negedge, model, check at the following negedge
  task automatic step(input logic tv, input logic ts, input logic [1:0] td,
                      input logic rv, input logic rs, input logic [1:0] rp,
                      input string req);
    logic [1:0] e_tx, e_rx, st, d, tb_ref, rb_ref;
    logic e_rx_v;
    tx_valid = tv; tx_sop = ts; tx_dibit = td;
    rx_valid = rv; rx_sop = rs; rx_phase = rp;
    tb_ref = ts ? 2'd0 : m_tx_ref;
    st = b_step(bpsk_mode ? {td[1], td[1]} : td);
    if (rev_dir) st = 2'(-st);
    if (tv) m_tx_ref = 2'(tb_ref + st);
    else if (ts) m_tx_ref = 2'd0;
    e_tx = m_tx_ref;
    rb_ref = rs ? 2'd0 : m_rx_ref;
    d = 2'(rp - rb_ref);
    if (rev_dir) d = 2'(-d);
    e_rx = bpsk_mode ? {d[1], d[1]} : b_dibit(d);
    e_rx_v = rv;
    if (rv) m_rx_ref = rp;
    else if (rs) m_rx_ref = 2'd0;
    @(negedge clk);
    check({req, " tx_phase"}, {2'b0, tx_phase}, {2'b0, e_tx});
    check({req, " tx_phase_valid"}, {3'b0, tx_phase_valid}, {3'b0, tv});
    check({req, " rx_out_valid"}, {3'b0, rx_out_valid}, {3'b0, e_rx_v});
    if (rv) check({req, " rx_dibit"}, {2'b0, rx_dibit}, {2'b0, e_rx});
  endtask

  initial begin
    void'($urandom(32'h5eed_0d1b));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset", {tx_phase_valid, rx_out_valid, tx_phase}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", {tx_phase_valid, rx_out_valid, tx_phase}, 4'b0000);

    // R1 and R2: every dibit, directed, in both paths
    for (int i = 0; i < 4; i++) step(1, 0, 2'(i), 1, 0, 2'(i * 3), "R1 R2 directed");
    // R8 idle cycles hold
    step(0, 0, 2'b11, 0, 0, 2'd2, "R8 idle");
    step(0, 0, 2'b01, 0, 0, 2'd1, "R8 idle");
    // R6 and R7 strobe without valid, then a symbol
    step(0, 1, 2'b00, 0, 1, 2'd0, "R6 R7 sop alone");
    step(1, 0, 2'b01, 1, 0, 2'd3, "R6 R7 after sop");
    // R3 reversal
    rev_dir = 1'b1;
    for (int i = 0; i < 4; i++) step(1, i == 0, 2'(i), 1, i == 0, 2'(i), "R3 reversed");
    rev_dir = 1'b0;
    // R4 and R5 two-point mode, including ignored tx_dibit[0] and +/-90 receive
    bpsk_mode = 1'b1;
    for (int i = 0; i < 8; i++) step(1, 0, 2'(i), 1, 0, 2'(i + i / 4), "R4 R5 two-point");
    rev_dir = 1'b1;
    for (int i = 0; i < 4; i++) step(1, 0, 2'(i), 1, 0, 2'(i * 3), "R4 R5 two-point reversed");
    rev_dir = 1'b0; bpsk_mode = 1'b0;

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 50) == 0) begin rev_dir = 1'($urandom); bpsk_mode = 1'($urandom); end
      step(1'($urandom % 4 != 0), 1'($urandom % 16 == 0), 2'($urandom),
           1'($urandom % 4 != 0), 1'($urandom % 16 == 0), 2'($urandom), "R1 R2 R3 R4 R5 R6 R7 R8 random");
    end

    // R10: loopback with one corrupted phase
    rev_dir = 1'b0; bpsk_mode = 1'b0;
    for (int i = 0; i < 20; i++) begin
      sent[i] = 2'($urandom);
      step(1, i == 0, sent[i], 0, 0, 2'd0, "R10 encode");
      phs[i] = tx_phase;
    end
    phs[10] = 2'(phs[10] + 1);
    for (int i = 0; i < 20; i++) begin
      step(0, 0, 2'd0, 1, i == 0, phs[i], "R10 decode");
      got[i] = rx_dibit;
    end
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) if (got[i] != sent[i]) bad++;
      check("R10 error pair count", 4'(bad), 4'd2);
      check("R10 pair position", {2'b0, 1'(got[10] != sent[10]), 1'(got[11] != sent[11])}, 4'b0011);
    end
    summary_and_end();
  end
endmodule